// File: doc/BRIEF.md
# Self-Aligned Floating-Point Multiplier

This block multiplies two numbers held in self-aligned form. Each operand has three fields: a reduced exponent, a signed two's complement mantissa, and a small shift field. The shift field holds the low bits of the full exponent that were moved into the mantissa. The product comes out in the same three-field form, so a later adder tree or accumulator can take it without unpacking or normalizing it first.

The exponent path rebuilds each full exponent by placing the shift field below the reduced exponent. It adds the two full exponents and subtracts a constant bias of 2^(EXP_W+SUB_W-1) - 1. The upper part of the result becomes the new reduced exponent and the lower part the new shift field. The mantissa path first shifts each mantissa right, arithmetically, by that operand's own shift field. It then multiplies the two as signed numbers and keeps a fixed window of the product.

The pipeline has two stages and takes a new operand pair on every cycle. Exponent arithmetic and the pre-shifts sit in the first stage, and the multiply sits in the second. The block does not saturate an out-of-range exponent and does not round the product.

Top module: `saf_mul`

## Requirements
- R1: While rst_n is low, and on the first edge after release, out_valid is 0 and z_exp, z_lsh and z_man are all zero.
- R2: out_valid equals in_valid from two rising edges earlier. A pair is accepted on every cycle with in_valid high, with no gaps needed between pairs.
- R3: z_exp is bits [EXP_W+SUB_W-1:SUB_W] of F = {a_exp,a_lsh} + {b_exp,b_lsh} - (2^(EXP_W+SUB_W-1) - 1). F is taken modulo 2^(EXP_W+SUB_W), and {x,y} places the SUB_W-bit shift field y below the EXP_W-bit exponent x.
- R4: z_lsh is bits [SUB_W-1:0] of the same F. With EXP_W >= 1 this equals a_lsh + b_lsh + 1 modulo 2^SUB_W.
- R5: Before the multiply, each signed mantissa is shifted right arithmetically by its own shift field. The sign is copied into the vacated bits, so a negative value rounds toward minus infinity (for example -1 shifted by 3 stays -1).
- R6: z_man is bits [PROD_LSB+PROD_W-1:PROD_LSB] of the full 2*MAN_W-bit signed product of the two shifted mantissas. The low PROD_LSB bits are dropped without rounding.
- R7: If either a_man or b_man is zero, z_man is zero, whatever the exponent fields hold.
- R8: If F falls below zero or reaches 2^(EXP_W+SUB_W), the exponent wraps modulo 2^(EXP_W+SUB_W) and is not clamped.
- R9: A cycle with in_valid low leaves z_exp, z_lsh and z_man unchanged when that slot reaches the output, two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on the inputs is valid |
| a_exp | input | EXP_W | Reduced exponent of operand A |
| a_lsh | input | SUB_W | Shift field of operand A |
| a_man | input | MAN_W | Signed mantissa of operand A |
| b_exp | input | EXP_W | Reduced exponent of operand B |
| b_lsh | input | SUB_W | Shift field of operand B |
| b_man | input | MAN_W | Signed mantissa of operand B |
| out_valid | output | 1 | Product on the outputs is valid |
| z_exp | output | EXP_W | Reduced exponent of the product |
| z_lsh | output | SUB_W | Shift field of the product |
| z_man | output | PROD_W | Signed mantissa window of the product |

## Verification
The bench first sends hand-picked pairs, each chosen to isolate one effect:
- Positive mantissas with zero shift fields check the product window and its binary point.
- Mixed-sign and doubly negative mantissas with nonzero shift fields show whether the pre-shift is arithmetic.
- A mantissa of -1 shifted by three shows whether the sign bits are kept rather than zeros shifted in.
- Full-scale negative operands test the top of the product window.
- A zero mantissa paired with a large exponent shows that the mantissa path ignores the exponent.
- The smallest and largest full exponents force the biased sum to wrap low and high.

After these, a long stream of random pairs with a random valid pattern checks the two-cycle latency under back-to-back input. The idle slots in that stream test that the outputs hold.

// File: rtl/saf_mul.sv
module saf_mul #(
  parameter int EXP_W    = 6,
  parameter int SUB_W    = 2,
  parameter int MAN_W    = 12,
  parameter int PROD_W   = 16,
  parameter int PROD_LSB = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [EXP_W-1:0]         a_exp,
  input  logic [SUB_W-1:0]         a_lsh,
  input  logic signed [MAN_W-1:0]  a_man,
  input  logic [EXP_W-1:0]         b_exp,
  input  logic [SUB_W-1:0]         b_lsh,
  input  logic signed [MAN_W-1:0]  b_man,
  output logic                     out_valid,
  output logic [EXP_W-1:0]         z_exp,
  output logic [SUB_W-1:0]         z_lsh,
  output logic signed [PROD_W-1:0] z_man
);
  localparam int FULL_W = EXP_W + SUB_W;
  localparam int RAW_W  = 2 * MAN_W;
  localparam logic [FULL_W:0] BIAS = (FULL_W+1)'((1 << (FULL_W - 1)) - 1);

  logic [FULL_W:0] exp_sum;
  assign exp_sum = {1'b0, a_exp, a_lsh} + {1'b0, b_exp, b_lsh} - BIAS;

  logic                    s1_v;
  logic [FULL_W-1:0]       s1_full;
  logic signed [MAN_W-1:0] s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_full <= '0;
      s1_a    <= '0;
      s1_b    <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_full <= exp_sum[FULL_W-1:0];
        s1_a    <= a_man >>> a_lsh;
        s1_b    <= b_man >>> b_lsh;
      end
    end
  end

  logic signed [RAW_W-1:0] raw;
  assign raw = RAW_W'(s1_a) * RAW_W'(s1_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      z_exp     <= '0;
      z_lsh     <= '0;
      z_man     <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        z_exp <= s1_full[FULL_W-1:SUB_W];
        z_lsh <= s1_full[SUB_W-1:0];
        z_man <= raw[PROD_LSB +: PROD_W];
      end
    end
  end
endmodule

// File: rtl/saf_mul_chk.sv
module saf_mul_chk #(
  parameter int EXP_W  = 6,
  parameter int SUB_W  = 2,
  parameter int MAN_W  = 12,
  parameter int PROD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [SUB_W-1:0]         a_lsh,
  input logic [MAN_W-1:0]         a_man,
  input logic [SUB_W-1:0]         b_lsh,
  input logic [MAN_W-1:0]         b_man,
  input logic                     out_valid,
  input logic [EXP_W-1:0]         z_exp,
  input logic [SUB_W-1:0]         z_lsh,
  input logic [PROD_W-1:0]        z_man
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    (since_rst == 2'd1) |-> (!out_valid && z_man == '0 && z_exp == '0 && z_lsh == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r4_lsh_field: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && out_valid) |->
      (z_lsh == SUB_W'($past(a_lsh, 2) + $past(b_lsh, 2) + 1'b1)));

  a_r7_zero_mantissa: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && $past(in_valid, 2) &&
     ($past(a_man, 2) == '0 || $past(b_man, 2) == '0)) |-> (z_man == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && !$past(in_valid, 2)) |->
      ($stable(z_man) && $stable(z_exp) && $stable(z_lsh)));
endmodule

bind saf_mul saf_mul_chk #(
  .EXP_W(EXP_W), .SUB_W(SUB_W), .MAN_W(MAN_W), .PROD_W(PROD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .a_lsh(a_lsh), .a_man(a_man), .b_lsh(b_lsh), .b_man(b_man),
  .out_valid(out_valid), .z_exp(z_exp), .z_lsh(z_lsh), .z_man(z_man)
);

// File: tb/saf_mul_test.sv
`timescale 1ns/1ps
module saf_mul_test;
  localparam int EW = 6, LW = 2, MW = 12, PW = 16, PL = 8;
  localparam int FW = EW + LW;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [LW-1:0] a_lsh = '0, b_lsh = '0;
  logic [MW-1:0] a_man = '0, b_man = '0;
  logic out_valid;
  logic [EW-1:0] z_exp;
  logic [LW-1:0] z_lsh;
  logic [PW-1:0] z_man;

  always #2.5 clk = ~clk;

  saf_mul #(.EXP_W(EW), .SUB_W(LW), .MAN_W(MW), .PROD_W(PW), .PROD_LSB(PL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_exp(a_exp), .a_lsh(a_lsh), .a_man(a_man),
    .b_exp(b_exp), .b_lsh(b_lsh), .b_man(b_man),
    .out_valid(out_valid), .z_exp(z_exp), .z_lsh(z_lsh), .z_man(z_man));

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit pv1 = 0, pv2 = 0;
  longint qe[$], ql[$], qm[$];
  string  te[$], tm[$];
  logic [63:0] last_out = '0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_out();
    check("R2", 64'(out_valid), 64'(pv2));
    if (pv2 && qe.size() > 0) begin
      check(te.pop_front(), 64'(z_exp), qe.pop_front());
      check("R4", 64'(z_lsh), ql.pop_front());
      check(tm.pop_front(), 64'(z_man), qm.pop_front());
    end else if (!pv2) begin
      check("R9", {40'd0, z_exp, z_lsh, z_man}, last_out);
    end
    last_out = {40'd0, z_exp, z_lsh, z_man};
  endtask

  task automatic step(bit v, int ae, int al, int am, int be, int bl, int bm);
    longint fa, fb, s, sm, ia, ib, p;
    @(negedge clk);
    check_out();
    in_valid = v;
    a_exp = EW'(ae); a_lsh = LW'(al); a_man = MW'(am);
    b_exp = EW'(be); b_lsh = LW'(bl); b_man = MW'(bm);
    pv2 = pv1; pv1 = v;
    if (v) begin
      fa = longint'(a_exp) * (1 << LW) + longint'(a_lsh);
      fb = longint'(b_exp) * (1 << LW) + longint'(b_lsh);
      s  = fa + fb - ((1 << (FW - 1)) - 1);
      sm = (s + 2 * (1 << FW)) % (1 << FW);
      qe.push_back(sm >> LW);
      ql.push_back(sm % (1 << LW));
      te.push_back((s < 0 || s >= (1 << FW)) ? "R8" : "R3");
      ia = longint'($signed(a_man)) >>> a_lsh;
      ib = longint'($signed(b_man)) >>> b_lsh;
      p  = ia * ib;
      qm.push_back((p >>> PL) & ((1 << PW) - 1));
      if (a_man == '0 || b_man == '0) tm.push_back("R7");
      else if (a_lsh != '0 || b_lsh != '0) tm.push_back("R5");
      else tm.push_back("R6");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1", {31'd0, out_valid, z_exp, z_lsh, z_man}, 64'd0);
    end
    rst_n = 1'b1;
    step(1, 20, 0, 256, 40, 0, 128);
    step(1, 33, 1, -300, 12, 3, 77);
    step(1, 5, 2, -1000, 7, 1, -555);
    step(1, 9, 3, -1, 9, 0, 2047);
    step(1, 63, 3, 0, 50, 2, 1234);
    step(1, 44, 1, 999, 31, 3, 0);
    step(1, 0, 0, 100, 0, 0, 100);
    step(1, 63, 3, 300, 63, 3, 300);
    step(1, 1, 0, -2048, 2, 0, -2048);
    step(1, 3, 0, -2048, 4, 0, 2047);
    step(0, 11, 2, 500, 12, 1, 600);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, int'($urandom % 64), int'($urandom % 4),
           int'($urandom % 4096), int'($urandom % 64), int'($urandom % 4),
           int'($urandom % 4096));
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule